// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a 32-bit physical address by reading translation descriptors from memory. A request carries the virtual address, the translation table base and a bit that enables tiny-page support. The walker reads one first-level descriptor and, depending on its type code, either finishes at once with a 1 MB section or reads a second-level descriptor from a coarse or fine table and finishes with a 64 KB, 4 KB or 1 KB page.

The result is the physical address together with the 2-bit cacheable/bufferable attribute taken from the final descriptor. A walk can also end in a fault. This happens for an invalid descriptor, for a fine table when tiny pages are disabled, or for an error response from memory, which is flagged separately. Memory is reached through a single-outstanding word read port. The block handles one walk at a time and reports completion with a one-cycle pulse.

Top module: `ptw_engine`

## Requirements
- R1: The first read address is `{req_tbase[31:14], req_vaddr[31:20], 2'b00}`, presented on `mem_rd_addr` in the cycle after the request is accepted.
- R2: A first-level descriptor whose bits 1:0 are `10` ends the walk after one read with `paddr = {desc[31:20], va[19:0]}` and `attr = desc[3:2]`.
- R3: A first-level type `01` makes the second read address `{desc[31:10], va[19:12], 2'b00}`.
- R4: A first-level type `11` with `req_tiny_en = 1` makes the second read address `{desc[31:12], va[19:10], 2'b00}`.
- R5: Second-level type `01` gives `{desc[31:16], va[15:0]}`, type `10` gives `{desc[31:12], va[11:0]}` and type `11` gives `{desc[31:10], va[9:0]}`. In every case `attr = desc[3:2]`.
- R6: First-level type `00`, first-level type `11` with tiny pages disabled, and second-level type `00` each end the walk with `fault = 1`, `rd_err = 0`, `paddr = 0` and `attr = 0`.
- R7: A response with `mem_rsp_err = 1` ends the walk at once with `fault = 1`, `rd_err = 1`, `paddr = 0` and `attr = 0`, and no further read is issued.
- R8: `req_ready` is high only when no walk is in progress. A `req_valid` seen while a walk is in progress has no effect.
- R9: `mem_rd_valid` and `mem_rd_addr` stay constant until a cycle with `mem_rsp_valid = 1`.
- R10: `done` is high for exactly one cycle, in the cycle after the last response. `fault`, `rd_err`, `paddr` and `attr` hold their values until the next completion.
- R11: Synchronous reset makes the block idle, with `mem_rd_valid = 0`, `done = 0`, `req_ready = 1` and all results cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | Translation table base |
| req_tiny_en | input | 1 | Enables fine tables and tiny pages at the first level |
| mem_rd_valid | output | 1 | Word read outstanding |
| mem_rd_addr | output | 32 | Word read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended without a translation |
| rd_err | output | 1 | The fault came from a memory error |
| paddr | output | 32 | Physical address |
| attr | output | 2 | Cacheable/bufferable attribute |

## Verification
The first read address can be sampled one cycle after the request is accepted. A second-level address appears one cycle after the first response. `done` and the results appear one cycle after the final response, and `done` must be low again one cycle later. The bench drives inputs on falling edges and holds back each response for zero to two extra cycles, during which it checks that the read address stays put and `done` stays low. It then samples each result on the falling edge that follows the exact rising edge at which that result is due.

// File: rtl/ptw_engine.sv
module ptw_engine (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] req_tbase,
  input  logic        req_tiny_en,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic        fault,
  output logic        rd_err,
  output logic [31:0] paddr,
  output logic [1:0]  attr
);

  typedef enum logic [1:0] {IDLE, LVL1, LVL2} state_t;

  state_t      st;
  logic [31:0] va_q;
  logic        tiny_q;

  wire        rsp  = mem_rd_valid && mem_rsp_valid;
  wire [1:0]  kind = mem_rsp_data[1:0];
  wire [31:0] d    = mem_rsp_data;

  assign req_ready    = (st == IDLE);
  assign mem_rd_valid = (st != IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= IDLE;
      va_q        <= '0;
      tiny_q      <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      rd_err      <= 1'b0;
      paddr       <= '0;
      attr        <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          va_q        <= req_vaddr;
          tiny_q      <= req_tiny_en;
          mem_rd_addr <= {req_tbase[31:14], req_vaddr[31:20], 2'b00};
          st          <= LVL1;
        end
        LVL1: if (rsp) begin
          if (mem_rsp_err) begin
            st <= IDLE; done <= 1'b1; fault <= 1'b1; rd_err <= 1'b1;
            paddr <= '0; attr <= '0;
          end else if (kind == 2'b10) begin
            st <= IDLE; done <= 1'b1; fault <= 1'b0; rd_err <= 1'b0;
            paddr <= {d[31:20], va_q[19:0]}; attr <= d[3:2];
          end else if (kind == 2'b01) begin
            mem_rd_addr <= {d[31:10], va_q[19:12], 2'b00};
            st          <= LVL2;
          end else if (kind == 2'b11 && tiny_q) begin
            mem_rd_addr <= {d[31:12], va_q[19:10], 2'b00};
            st          <= LVL2;
          end else begin
            st <= IDLE; done <= 1'b1; fault <= 1'b1; rd_err <= 1'b0;
            paddr <= '0; attr <= '0;
          end
        end
        LVL2: if (rsp) begin
          st   <= IDLE;
          done <= 1'b1;
          if (mem_rsp_err || kind == 2'b00) begin
            fault <= 1'b1; rd_err <= mem_rsp_err;
            paddr <= '0; attr <= '0;
          end else begin
            fault <= 1'b0; rd_err <= 1'b0; attr <= d[3:2];
            case (kind)
              2'b01:   paddr <= {d[31:16], va_q[15:0]};
              2'b10:   paddr <= {d[31:12], va_q[11:0]};
              default: paddr <= {d[31:10], va_q[9:0]};
            endcase
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_engine_chk.sv
module ptw_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rsp_valid,
  input logic        mem_rsp_err,
  input logic        done,
  input logic        fault,
  input logic        rd_err,
  input logic [31:0] paddr,
  input logic [1:0]  attr
);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_valid && mem_rsp_valid) |=> ($stable(paddr) && $stable(attr) && $stable(fault) && $stable(rd_err) && !done));

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && mem_rsp_valid && mem_rsp_err) |=> (done && fault && rd_err && !mem_rd_valid));

  // R6
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == 32'd0 && attr == 2'd0));

endmodule

bind ptw_engine ptw_engine_chk chk_i (.*);

// File: tb/ptw_engine_test.sv
`timescale 1ns/1ps
module ptw_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_tbase = '0;
  logic        req_tiny_en = 1'b0;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done, fault, rd_err;
  logic [31:0] paddr;
  logic [1:0]  attr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ptw_engine uut (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] tb;
    logic        tiny;
    logic [31:0] d1;
    logic        e1;
    logic        two;
    logic [31:0] d2;
    logic        e2;
    logic [31:0] a1;
    logic [31:0] a2;
    logic        flt;
    logic        rerr;
    logic [31:0] pa;
    logic [1:0]  at;
    logic [3:0]  rqa;
    logic [3:0]  rqr;
  } vec_t;

  // rqa: requirement of the second address, rqr: requirement of the result
  localparam vec_t VECS [11] = '{
    // R2 section
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h5670000A, 1'b0, 1'b0, 32'h0, 1'b0, 32'h12346AF0, 32'h0, 1'b0, 1'b0, 32'h56712345, 2'd2, 4'd1, 4'd2},
    // R2 section, all-ones address
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h00100006, 1'b0, 1'b0, 32'h0, 1'b0, 32'hFFFFFFFC, 32'h0, 1'b0, 1'b0, 32'h001FFFFF, 2'd1, 4'd1, 4'd2},
    // R3 coarse, R5 small page
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h87654321, 1'b0, 1'b1, 32'h0BADF00E, 1'b0, 32'h12346AF0, 32'h87654048, 1'b0, 1'b0, 32'h0BADF345, 2'd3, 4'd3, 4'd5},
    // R3 coarse, R5 large page
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h87654321, 1'b0, 1'b1, 32'h13570005, 1'b0, 32'h12346AF0, 32'h87654048, 1'b0, 1'b0, 32'h13572345, 2'd1, 4'd3, 4'd5},
    // R4 fine, R5 tiny page
    '{32'hABC12345, 32'h12347FFF, 1'b1, 32'h24680003, 1'b0, 1'b1, 32'hFEDCBA0F, 1'b0, 32'h12346AF0, 32'h24680120, 1'b0, 1'b0, 32'hFEDCBB45, 2'd3, 4'd4, 4'd5},
    // R4 fine, R5 small page
    '{32'hABC12345, 32'h12347FFF, 1'b1, 32'h24680003, 1'b0, 1'b1, 32'h0BADF00E, 1'b0, 32'h12346AF0, 32'h24680120, 1'b0, 1'b0, 32'h0BADF345, 2'd3, 4'd4, 4'd5},
    // R6 fine table with tiny pages disabled
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h24680003, 1'b0, 1'b0, 32'h0, 1'b0, 32'h12346AF0, 32'h0, 1'b1, 1'b0, 32'h0, 2'd0, 4'd1, 4'd6},
    // R6 first-level fault
    '{32'hABC12345, 32'h12347FFF, 1'b1, 32'h12345670, 1'b0, 1'b0, 32'h0, 1'b0, 32'h12346AF0, 32'h0, 1'b1, 1'b0, 32'h0, 2'd0, 4'd1, 4'd6},
    // R6 second-level fault
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h87654321, 1'b0, 1'b1, 32'h0000FFFC, 1'b0, 32'h12346AF0, 32'h87654048, 1'b1, 1'b0, 32'h0, 2'd0, 4'd3, 4'd6},
    // R7 first read error
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h5670000A, 1'b1, 1'b0, 32'h0, 1'b0, 32'h12346AF0, 32'h0, 1'b1, 1'b1, 32'h0, 2'd0, 4'd1, 4'd7},
    // R7 second read error
    '{32'hABC12345, 32'h12347FFF, 1'b0, 32'h87654321, 1'b0, 1'b1, 32'h0BADF00E, 1'b1, 32'h12346AF0, 32'h87654048, 1'b1, 1'b1, 32'h0, 2'd0, 4'd3, 4'd7}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic respond(input logic [31:0] data, input logic err);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    mem_rsp_err   = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_rsp_err   = 1'b0;
  endtask

  task automatic wait_hold(input int lat, input logic [31:0] addr);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R9", "held address", mem_rd_addr, addr);
      chk("R10", "done while waiting", {31'd0, done}, 32'd0);
    end
  endtask

  task automatic run_vec(input vec_t v, input int lat);
    string rqa, rqr;
    rqa = $sformatf("R%0d", v.rqa);
    rqr = $sformatf("R%0d", v.rqr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_tbase = v.tb; req_tiny_en = v.tiny;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "ready while busy", {31'd0, req_ready}, 32'd0);
    chk("R1", "first read addr", mem_rd_addr, v.a1);
    chk("R1", "read valid", {31'd0, mem_rd_valid}, 32'd1);
    wait_hold(lat, v.a1);
    respond(v.d1, v.e1);
    if (v.two) begin
      chk(rqa, "second read addr", mem_rd_addr, v.a2);
      chk(rqa, "second read valid", {31'd0, mem_rd_valid}, 32'd1);
      wait_hold(lat, v.a2);
      respond(v.d2, v.e2);
    end
    chk("R10", "done pulse", {31'd0, done}, 32'd1);
    chk(rqr, "fault", {31'd0, fault}, {31'd0, v.flt});
    chk(rqr, "rd_err", {31'd0, rd_err}, {31'd0, v.rerr});
    chk(rqr, "paddr", paddr, v.pa);
    chk(rqr, "attr", {30'd0, attr}, {30'd0, v.at});
    chk(rqr, "no further read", {31'd0, mem_rd_valid}, 32'd0);
    @(negedge clk);
    chk("R10", "done cleared", {31'd0, done}, 32'd0);
    chk("R10", "paddr held", paddr, v.pa);
    chk("R10", "fault held", {31'd0, fault}, {31'd0, v.flt});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R11", "no read after reset", {31'd0, mem_rd_valid}, 32'd0);
    chk("R11", "done after reset", {31'd0, done}, 32'd0);
    chk("R11", "paddr after reset", paddr, 32'd0);

    for (int i = 0; i < 11; i++) run_vec(VECS[i], i % 3);

    // R8 a request during a walk is ignored
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'hABC12345; req_tbase = 32'h12347FFF; req_tiny_en = 1'b0;
    @(negedge clk);
    req_vaddr = 32'h0; req_tbase = 32'h0;
    chk("R8", "ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "addr unchanged", mem_rd_addr, 32'h12346AF0);
    respond(32'h5670000A, 1'b0);
    chk("R8", "original va result", paddr, 32'h56712345);
    chk("R8", "done", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R8", "no new walk", {31'd0, mem_rd_valid}, 32'd0);

    // R11 reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'hABC12345; req_tbase = 32'h12347FFF;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "read dropped", {31'd0, mem_rd_valid}, 32'd0);
    chk("R11", "ready", {31'd0, req_ready}, 32'd1);
    chk("R11", "done low", {31'd0, done}, 32'd0);
    chk("R11", "paddr cleared", paddr, 32'd0);

    // after reset a normal walk still completes
    run_vec(VECS[2], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule